// File: doc/BRIEF.md
# Line-Latched Sequential Word Reader

This block is the read front-end for a wide on-chip storage array. The array is organised in lines of four 64-bit words. When a request misses, the array is enabled once and the whole 256-bit line is captured into a line register. A 4:1 word selector placed after that register returns the addressed word. The block remembers which line the register holds. A later request to any word of that same line, which covers the usual case of the next sequential word, is answered from the register and the array stays disabled.

Requesters present a word address with a valid/ready handshake. Each accepted request is answered exactly one cycle later on a valid-qualified 64-bit data output. The register between the array and the selector is what costs this cycle. A word-wide write port updates the array directly. A parameter selects what happens when a write hits the line being held: the word is patched into the register, or the register is marked empty. A free-running counter of array read enables lets a test confirm the power saving.

Top module: `wide_line_reader`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` is 0, `act_count` is 0, the line register holds nothing, and the first read that follows is an array read.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) is answered with `rsp_valid` high during the following cycle only. No response appears without an accepted request.
- R3: The line index is `req_addr[5:2]` and the word index is `req_addr[1:0]`. Word k of a line occupies line bits 64k+63 down to 64k, and `rsp_data` equals the word last written to that address.
- R4: A request whose line index equals the held line, while the register is valid, causes no array read, and `act_count` does not change. This holds in any word order within the line, including repeats.
- R5: A request to a different line, or any request while the register is empty, enables the array exactly once, reloads the register, and adds 1 to `act_count`.
- R6: A stream of 4N sequential word reads that starts on a line boundary adds exactly N to `act_count`.
- R7: With the default patch policy, a write to the held line changes the matching word in the register. A following read of that word returns the new data without an array read.
- R8: A write to a line that is not held leaves the held line and its hit status unchanged. A later read of the written line returns the new data through an array read.
- R9: While `wr_en` is high, `req_ready` is low and a presented request is ignored: no response follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request can be taken this cycle |
| req_addr | input | 6 | Word address of the read |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data word |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 64 | Word to write |
| act_count | output | 32 | Number of array read enables since reset |

## Verification
The hardest case to reach from the ports is a write that lands on the exact line the register is holding, placed between reads that should hit. The bench tracks the held line itself and first reads a chosen line to make it resident. It then writes one of that line's words and reads it back, expecting the new value with no change in the activity count. A write to an unrelated line follows, and the resident line must still hit afterwards. The full-array sequential sweep and a stride-7 sweep, which misses on every request, pin down the array-read accounting.

// File: rtl/wlr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the line-latched word reader.
// Assumes: nothing beyond IEEE 1800-2017.
package wlr_pkg;

    // Policy for a write that targets the line currently held in the register.
    typedef enum logic {
        POL_PATCH = 1'b0,  // copy the written word into the held line
        POL_DROP  = 1'b1   // mark the held line empty
    } wr_policy_e;

endpackage

// File: rtl/wlr_line_array.sv
`timescale 1ns/1ps
// Module: wlr_line_array
// Synthesizable model of the wide storage array. A read returns a whole
// line combinationally while rd_en is high, and zero otherwise. A write
// updates one word of a line on the clock edge.
// Assumes: callers never need read-during-write forwarding, because the
// top blocks reads while a write is in progress.
module wlr_line_array #(
    parameter int WORD_W = 64,
    parameter int WPL    = 4,
    parameter int LINES  = 16,
    localparam int LINE_W = WORD_W * WPL,
    localparam int OFF_W  = $clog2(WPL),
    localparam int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_line,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_line,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data
);

    logic [LINE_W-1:0] mem [LINES];

    // Purpose: store one written word into its line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_line][wr_off*WORD_W +: WORD_W] <= wr_data;
        end
    end

    // Purpose: drive the line outputs only while the array is enabled.
    always_comb begin
        rd_data = rd_en ? mem[rd_line] : '0;
    end

endmodule

// File: rtl/wlr_tag_track.sv
`timescale 1ns/1ps
// Module: wlr_tag_track
// Records which line the register holds (tag plus valid bit). It decides
// hit or miss for each request and detects writes aimed at the held line.
// Assumes: a read and a write are never accepted in the same cycle.
module wlr_tag_track
    import wlr_pkg::*;
#(
    parameter int         IDX_W     = 4,
    parameter wr_policy_e WR_POLICY = POL_PATCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic [IDX_W-1:0] req_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_line,
    output logic             line_load,
    output logic             wr_hit
);

    logic [IDX_W-1:0] tag_q;
    logic             valid_q;
    logic             req_hit;
    logic             drop_line;

    // Purpose: compare the incoming addresses against the held tag.
    always_comb begin
        req_hit   = valid_q && (req_line == tag_q);
        line_load = req_fire && !req_hit;
        wr_hit    = wr_en && valid_q && (wr_line == tag_q);
    end

    // The write policy decides whether a write hit empties the register.
    generate
        if (WR_POLICY == POL_DROP) begin : g_drop
            assign drop_line = wr_hit;
        end else begin : g_keep
            assign drop_line = 1'b0;
        end
    endgenerate

    // Purpose: update the tag on a reload and the valid bit on reload or drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else if (line_load) begin
            tag_q   <= req_line;
            valid_q <= 1'b1;
        end else if (drop_line) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wlr_line_hold.sv
`timescale 1ns/1ps
// Module: wlr_line_hold
// Line register, word-offset register and response flag, plus the word
// selector after the register. The response appears one cycle after
// acceptance.
// Assumes: line_load and patch_en are never high together.
module wlr_line_hold #(
    parameter int WORD_W = 64,
    parameter int WPL    = 4,
    localparam int LINE_W = WORD_W * WPL,
    localparam int OFF_W  = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              line_load,
    input  logic [LINE_W-1:0] line_in,
    input  logic              patch_en,
    input  logic [OFF_W-1:0]  patch_off,
    input  logic [WORD_W-1:0] patch_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data
);

    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  off_q;
    logic              rvalid_q;
    logic [WORD_W-1:0] words [WPL];

    // Purpose: capture a fresh line on a miss, or patch one word on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (line_load) begin
            line_q <= line_in;
        end else if (patch_en) begin
            line_q[patch_off*WORD_W +: WORD_W] <= patch_data;
        end
    end

    // Purpose: remember the word offset and that a response is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= req_fire;
            if (req_fire) begin
                off_q <= req_off;
            end
        end
    end

    // Split the held line into its words.
    generate
        for (genvar k = 0; k < WPL; k++) begin : g_word
            assign words[k] = line_q[k*WORD_W +: WORD_W];
        end
    endgenerate

    // Purpose: pick the addressed word out of the held line.
    always_comb begin
        rsp_data  = words[off_q];
        rsp_valid = rvalid_q;
    end

endmodule

// File: rtl/wide_line_reader.sv
`timescale 1ns/1ps
// Module: wide_line_reader (top)
// Word reader in front of a wide array. A miss enables the array once
// and latches the whole line. Hits in the same line come from the latched
// copy. Counts array read enables.
// Assumes: a write takes priority over a read in the same cycle.
module wide_line_reader
    import wlr_pkg::*;
#(
    parameter int         WORD_W    = 64,
    parameter int         WPL       = 4,
    parameter int         LINES     = 16,
    parameter int         CNT_W     = 32,
    parameter wr_policy_e WR_POLICY = POL_PATCH,
    localparam int LINE_W = WORD_W * WPL,
    localparam int OFF_W  = $clog2(WPL),
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CNT_W-1:0]  act_count
);

    logic              req_fire;
    logic [IDX_W-1:0]  req_line;
    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  wr_line;
    logic [OFF_W-1:0]  wr_off;
    logic              line_load;
    logic              wr_hit;
    logic              patch_en;
    logic [LINE_W-1:0] array_line;
    logic [CNT_W-1:0]  act_q;

    // Purpose: handshake and address split into line index and word index.
    always_comb begin
        req_ready = !wr_en;
        req_fire  = req_valid && req_ready;
        req_line  = req_addr[ADDR_W-1:OFF_W];
        req_off   = req_addr[OFF_W-1:0];
        wr_line   = wr_addr[ADDR_W-1:OFF_W];
        wr_off    = wr_addr[OFF_W-1:0];
    end

    // The policy selects whether a write hit patches the held line.
    generate
        if (WR_POLICY == POL_PATCH) begin : g_patch
            assign patch_en = wr_hit;
        end else begin : g_nopatch
            assign patch_en = 1'b0;
        end
    endgenerate

    wlr_tag_track #(
        .IDX_W     (IDX_W),
        .WR_POLICY (WR_POLICY)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_line  (req_line),
        .wr_en     (wr_en),
        .wr_line   (wr_line),
        .line_load (line_load),
        .wr_hit    (wr_hit)
    );

    wlr_line_array #(
        .WORD_W (WORD_W),
        .WPL    (WPL),
        .LINES  (LINES)
    ) u_array (
        .clk     (clk),
        .rd_en   (line_load),
        .rd_line (req_line),
        .rd_data (array_line),
        .wr_en   (wr_en),
        .wr_line (wr_line),
        .wr_off  (wr_off),
        .wr_data (wr_data)
    );

    wlr_line_hold #(
        .WORD_W (WORD_W),
        .WPL    (WPL)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .req_off    (req_off),
        .line_load  (line_load),
        .line_in    (array_line),
        .patch_en   (patch_en),
        .patch_off  (wr_off),
        .patch_data (wr_data),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    // Purpose: count each cycle in which the array is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (line_load) begin
            act_q <= act_q + 1'b1;
        end
    end

    assign act_count = act_q;

endmodule

// File: rtl/wlr_checker.sv
`timescale 1ns/1ps
// Module: wlr_checker
// Port-level properties of wide_line_reader, attached with bind.
// Assumes: the default patch write policy for the sequential-hit property.
module wlr_checker #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              wr_en,
    input logic [CNT_W-1:0]  act_count
);

    logic fire;
    assign fire = req_valid && req_ready;

    // R1: the cycle after a reset edge is quiet with a zero count.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && act_count == '0));

    // R2: every accepted request gets a response on the next cycle.
    p_rsp_after_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);

    // R2: no response appears without an accepted request.
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);

    // R4: the next word in the same line, back to back, reads no array.
    p_seq_hit_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(fire) && req_addr[1:0] != 2'd0
         && req_addr == ADDR_W'($past(req_addr) + 1'b1))
        |=> act_count == $past(act_count));

    // R5: the activity count never moves by more than one per cycle.
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (act_count == $past(act_count)
                  || act_count == CNT_W'($past(act_count) + 1'b1)));

    // R9: a write holds the request side off.
    p_write_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !req_ready);

endmodule

bind wide_line_reader wlr_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .wr_en     (wr_en),
    .act_count (act_count)
);

// File: tb/wide_line_reader_bench.sv
`timescale 1ns/1ps
// Bench for wide_line_reader: sweeps the whole 64-word default array.
module wide_line_reader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] act_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] mdl [64];
    bit          held_v = 1'b0;
    int          held_line = 0;

    always #2.5 clk = ~clk;

    wide_line_reader u_wide_line_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .act_count (act_count)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pattern(input int a, input int gen);
        return {24'hC0FFEE, 8'(a), 32'(a + 1) * 32'h9E3779B9 ^ 32'(gen)};
    endfunction

    // Read with valid left high, so back-to-back calls stream.
    task automatic rd(input int a, input string req);
        bit miss;
        logic [31:0] c0;
        miss = !held_v || ((a >> 2) != held_line);
        c0 = act_count;
        req_valid = 1'b1;
        req_addr  = 6'(a);
        @(negedge clk);
        chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_data == mdl[a], {req, " rsp_data"}, rsp_data, mdl[a]);
        chk(act_count == c0 + 32'(miss), {req, " act_count"},
            64'(act_count), 64'(c0 + 32'(miss)));
        held_v = 1'b1;
        held_line = a >> 2;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Write, optionally presenting a read at the same time (R9 probe).
    task automatic wr(input int a, input logic [63:0] d, input bit probe);
        req_valid = probe;
        req_addr  = 6'(a);
        wr_en     = 1'b1;
        wr_addr   = 6'(a);
        wr_data   = d;
        #0.1;
        chk(req_ready == 1'b0, "R9 ready low during write", 64'(req_ready), 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b0;
        if (probe) begin
            chk(rsp_valid == 1'b0, "R9 blocked request ignored", 64'(rsp_valid), 64'd0);
        end
        mdl[a] = d;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] c_start;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk(act_count == 32'd0, "R1 act_count in reset", 64'(act_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R9 ready when no write", 64'(req_ready), 64'd1);

        // Fill the array; nothing is held, so no reads are counted.
        for (int a = 0; a < 64; a++) wr(a, pattern(a, 0), 1'b0);
        chk(act_count == 32'd0, "R5 writes are not array reads", 64'(act_count), 64'd0);

        // R1 R3 R4 R5 R6: full sequential sweep, 64 words cost 16 array reads.
        c_start = act_count;
        for (int a = 0; a < 64; a++) rd(a, "R3 sequential sweep");
        idle();
        chk(act_count - c_start == 32'd16, "R6 sweep of 64 words", 64'(act_count - c_start), 64'd16);

        // R5: stride 7 never stays in a line, every request reads the array.
        c_start = act_count;
        for (int i = 0; i < 64; i++) rd((i * 7) % 64, "R5 stride sweep");
        idle();
        chk(act_count - c_start == 32'd64, "R5 stride total", 64'(act_count - c_start), 64'd64);

        // R4: repeats and reverse order inside one line.
        rd(23, "R4 first touch");
        rd(23, "R4 repeat");
        rd(23, "R4 repeat");
        for (int a = 23; a >= 20; a--) rd(a, "R4 reverse in line");
        idle();

        // R7: write to the held line, then read it back as a hit.
        rd(8, "R7 make line resident");
        idle();
        wr(10, 64'hDEAD_BEEF_0000_0A0A, 1'b1);
        rd(10, "R7 patched word hit");
        rd(8, "R7 neighbour unchanged");
        rd(11, "R7 neighbour unchanged");
        idle();

        // R8: write elsewhere, held line still hits, written line reads fresh.
        wr(40, 64'h0123_4567_89AB_CDEF, 1'b1);
        rd(9, "R8 held line still hits");
        rd(40, "R8 written line via array");
        rd(41, "R8 hit after reload");
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule